// File: doc/BRIEF.md
# DMA Address Write Shadow Tracker

This block watches byte-wide I/O writes headed for a legacy four-channel DMA controller and keeps, for each channel, a shadow copy of the 16-bit start address and of the page byte. Writes to the channel address ports are captured and not forwarded. One toggle, shared by all four channels, decides whether a captured byte is the low byte or the high byte. A write to the byte-pointer reset port clears that toggle and is still forwarded.

A write to a page port is range-checked. A legal page is stored, and the block then raises a one-cycle translate request. The request carries the channel index and the channel's full 20-bit virtual address, so that a remapping stage can program the real controller. A page that would reach past 1 MB raises a sticky fatal error, and so does any write into the undefined gap between the page ports. Once the error is set, nothing more is tracked or forwarded. Writes to every other port are flagged for forwarding to the real hardware.

Top module: `dma_shadow_tracker`

## Requirements
- R1: After reset every output is low or zero, the toggle is 0 and all channel address and page shadows are zero.
- R2: A write to port 0x00, 0x02, 0x04 or 0x06 (channel = port/2) stores the data byte into that channel's low address byte when the toggle is 0 and into its high byte when the toggle is 1. It then inverts the toggle and asserts neither pass_o nor xlate_req_o.
- R3: The toggle is shared across channels: a write to one channel's address port while the toggle is 1 lands in the high byte of that channel, even if the previous address write went to a different channel.
- R4: A write to port 0x0C clears the toggle and asserts pass_o for one cycle, starting the cycle after the write.
- R5: A write to a page port (0x87 channel 0, 0x83 channel 1, 0x81 channel 2, 0x82 channel 3) with data below 0x10 stores the low four data bits as that channel's page. In the next cycle it asserts xlate_req_o for one cycle, with xlate_chan_o equal to the channel and xlate_vaddr_o equal to {page[3:0], high byte, low byte}.
- R6: A page-port write with data of 0x10 or more sets fatal_o from the next cycle on. It asserts neither xlate_req_o nor pass_o, and it leaves the page shadow unchanged.
- R7: A write to port 0x84, 0x85 or 0x86 sets fatal_o from the next cycle on, with no request and no pass-through.
- R8: A write to any other port asserts pass_o for one cycle, starting the cycle after the write, and leaves the toggle and all shadows unchanged.
- R9: fatal_o stays high until reset. While it is high, writes change no state and assert neither pass_o nor xlate_req_o.
- R10: In a cycle after one with no write, pass_o and xlate_req_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | I/O byte write strobe |
| wr_port_i | input | 16 | I/O port number of the write |
| wr_data_i | input | 8 | Data byte of the write |
| pass_o | output | 1 | Pulse: forward this write to the real port |
| xlate_req_o | output | 1 | Pulse: translate request for a channel |
| xlate_chan_o | output | 2 | Channel of the translate request |
| xlate_vaddr_o | output | 20 | Virtual DMA address of the requested channel |
| fatal_o | output | 1 | Sticky fatal error |

## Verification
The bench targets the shared toggle. It interleaves address writes across channels, so a design with a separate toggle per channel puts bytes in the wrong half of the address. It places 0x0C writes between the two halves of an address, so a design that ignores the pointer reset leaves a byte in the high half. Page values of exactly 0x0F and 0x10 test the range boundary. Here an off-by-one either raises a false fatal error or translates an address beyond 1 MB. Writes to the gap ports and to untracked ports that sit next to the address ports (count ports, 0x08, 0x80) check that the decoder neither forwards an error case nor corrupts a shadow. Writes after a fatal error confirm that the error is sticky and that nothing leaks out.

// File: rtl/dma_shadow_pkg.sv
package dma_shadow_pkg;
  localparam int unsigned NUM_CHAN = 4;
  localparam int unsigned CHAN_W   = $clog2(NUM_CHAN);
  localparam int unsigned BYTE_W   = 8;

  typedef logic [CHAN_W-1:0] chan_t;

  typedef enum logic [2:0] {
    K_OTHER,
    K_ADDR,
    K_CLR,
    K_PAGE,
    K_GAP
  } port_kind_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_shadow_pkg::*;
#(
  parameter int unsigned PORT_W = 16
) (
  input  logic [PORT_W-1:0] port_i,
  output port_kind_e        kind_o,
  output chan_t             chan_o
);
  localparam logic [PORT_W-1:0] P_CLR   = PORT_W'(16'h000C);
  localparam logic [PORT_W-1:0] P_PG0   = PORT_W'(16'h0087);
  localparam logic [PORT_W-1:0] P_PG1   = PORT_W'(16'h0083);
  localparam logic [PORT_W-1:0] P_PG2   = PORT_W'(16'h0081);
  localparam logic [PORT_W-1:0] P_PG3   = PORT_W'(16'h0082);
  localparam logic [PORT_W-1:0] P_GAP_L = PORT_W'(16'h0084);
  localparam logic [PORT_W-1:0] P_GAP_H = PORT_W'(16'h0086);
  localparam logic [PORT_W-1:0] P_ADDR_END = PORT_W'(2 * NUM_CHAN);

  always_comb begin
    kind_o = K_OTHER;
    chan_o = '0;
    if (port_i < P_ADDR_END && !port_i[0]) begin
      kind_o = K_ADDR;
      chan_o = port_i[CHAN_W:1];
    end else if (port_i == P_CLR) begin
      kind_o = K_CLR;
    end else if (port_i == P_PG0) begin
      kind_o = K_PAGE;
      chan_o = chan_t'(0);
    end else if (port_i == P_PG1) begin
      kind_o = K_PAGE;
      chan_o = chan_t'(1);
    end else if (port_i == P_PG2) begin
      kind_o = K_PAGE;
      chan_o = chan_t'(2);
    end else if (port_i == P_PG3) begin
      kind_o = K_PAGE;
      chan_o = chan_t'(3);
    end else if (port_i >= P_GAP_L && port_i <= P_GAP_H) begin
      kind_o = K_GAP;
    end
  end
endmodule

// File: rtl/dma_shadow_bank.sv
module dma_shadow_bank
  import dma_shadow_pkg::*;
#(
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned VADDR_W = PAGE_W + 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lo_we_i,
  input  logic               hi_we_i,
  input  logic               pg_we_i,
  input  chan_t              wr_chan_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  chan_t              rd_chan_i,
  output logic [VADDR_W-1:0] rd_vaddr_o
);
  logic [BYTE_W-1:0] lo_q [NUM_CHAN];
  logic [BYTE_W-1:0] hi_q [NUM_CHAN];
  logic [PAGE_W-1:0] pg_q [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic sel;
    assign sel = (wr_chan_i == chan_t'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[c] <= '0;
        hi_q[c] <= '0;
        pg_q[c] <= '0;
      end else begin
        if (sel && lo_we_i) lo_q[c] <= byte_i;
        if (sel && hi_we_i) hi_q[c] <= byte_i;
        if (sel && pg_we_i) pg_q[c] <= page_i;
      end
    end
  end

  assign rd_vaddr_o = {pg_q[rd_chan_i], hi_q[rd_chan_i], lo_q[rd_chan_i]};
endmodule

// File: rtl/dma_shadow_tracker.sv
module dma_shadow_tracker
  import dma_shadow_pkg::*;
#(
  parameter int unsigned PORT_W = 16,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned VADDR_W = PAGE_W + 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [PORT_W-1:0]  wr_port_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  output logic               pass_o,
  output logic               xlate_req_o,
  output chan_t              xlate_chan_o,
  output logic [VADDR_W-1:0] xlate_vaddr_o,
  output logic               fatal_o
);
  port_kind_e kind;
  chan_t      dec_chan;
  logic       toggle_q, fatal_q, pass_q, req_q;
  chan_t      chan_q;
  logic       live, page_ok;
  logic       lo_we, hi_we, pg_we;

  dma_port_decode #(.PORT_W(PORT_W)) u_dec (
    .port_i (wr_port_i),
    .kind_o (kind),
    .chan_o (dec_chan)
  );

  assign live    = wr_valid_i && !fatal_q;
  assign page_ok = (wr_data_i[BYTE_W-1:PAGE_W] == '0);
  assign lo_we   = live && kind == K_ADDR && !toggle_q;
  assign hi_we   = live && kind == K_ADDR &&  toggle_q;
  assign pg_we   = live && kind == K_PAGE && page_ok;

  dma_shadow_bank #(.PAGE_W(PAGE_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lo_we_i    (lo_we),
    .hi_we_i    (hi_we),
    .pg_we_i    (pg_we),
    .wr_chan_i  (dec_chan),
    .byte_i     (wr_data_i),
    .page_i     (wr_data_i[PAGE_W-1:0]),
    .rd_chan_i  (chan_q),
    .rd_vaddr_o (xlate_vaddr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q <= 1'b0;
      fatal_q  <= 1'b0;
      pass_q   <= 1'b0;
      req_q    <= 1'b0;
      chan_q   <= '0;
    end else begin
      pass_q <= 1'b0;
      req_q  <= 1'b0;
      if (live) begin
        unique case (kind)
          K_ADDR:  toggle_q <= !toggle_q;
          K_CLR: begin
            toggle_q <= 1'b0;
            pass_q   <= 1'b1;
          end
          K_PAGE: begin
            if (page_ok) begin
              req_q  <= 1'b1;
              chan_q <= dec_chan;
            end else begin
              fatal_q <= 1'b1;
            end
          end
          K_GAP:   fatal_q <= 1'b1;
          default: pass_q  <= 1'b1;
        endcase
      end
    end
  end

  assign pass_o       = pass_q;
  assign xlate_req_o  = req_q;
  assign xlate_chan_o = chan_q;
  assign fatal_o      = fatal_q;
endmodule

// File: rtl/dma_shadow_tracker_chk.sv
module dma_shadow_tracker_chk
  import dma_shadow_pkg::*;
#(
  parameter int unsigned PORT_W = 16,
  parameter int unsigned PAGE_W = 4,
  localparam int unsigned VADDR_W = PAGE_W + 2 * BYTE_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_valid_i,
  input logic [PORT_W-1:0]  wr_port_i,
  input logic [BYTE_W-1:0]  wr_data_i,
  input logic               pass_o,
  input logic               xlate_req_o,
  input chan_t              xlate_chan_o,
  input logic [VADDR_W-1:0] xlate_vaddr_o,
  input logic               fatal_o
);
  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o); // R9

  AST_QUIET_AFTER_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> !pass_o && !xlate_req_o); // R9

  AST_BAD_PAGE_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_port_i == PORT_W'(16'h0087) && wr_data_i >= 8'h10)
      |=> fatal_o && !xlate_req_o && !pass_o); // R6

  AST_GAP_FATAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_port_i == PORT_W'(16'h0085)) |=> fatal_o); // R7

  AST_CLR_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_port_i == PORT_W'(16'h000C) && !fatal_o) |=> pass_o); // R4

  AST_PAGE_REQ_CH1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_port_i == PORT_W'(16'h0083) && wr_data_i < 8'h10 && !fatal_o)
      |=> xlate_req_o && xlate_chan_o == chan_t'(1)); // R5

  AST_ADDR_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_port_i == PORT_W'(16'h0004)) |=> !pass_o && !xlate_req_o); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !pass_o && !xlate_req_o); // R10
endmodule

bind dma_shadow_tracker dma_shadow_tracker_chk #(.PORT_W(PORT_W), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/dma_shadow_tracker_tb.sv
module dma_shadow_tracker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [15:0] wr_port_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        pass_o, xlate_req_o, fatal_o;
  logic [1:0]  xlate_chan_o;
  logic [19:0] xlate_vaddr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lo [4];
  logic [7:0] m_hi [4];
  logic [3:0] m_pg [4];
  bit m_tog, m_fat;

  always #5 clk_i = ~clk_i;

  dma_shadow_tracker u_dut (.*);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // 0 other, 1 addr, 2 clear, 3 page, 4 gap
  function automatic int kind_of(logic [15:0] p, output int ch);
    ch = 0;
    if (p inside {16'h0, 16'h2, 16'h4, 16'h6}) begin ch = p / 2; return 1; end
    if (p == 16'h0C) return 2;
    if (p == 16'h87) begin ch = 0; return 3; end
    if (p == 16'h83) begin ch = 1; return 3; end
    if (p == 16'h81) begin ch = 2; return 3; end
    if (p == 16'h82) begin ch = 3; return 3; end
    if (p >= 16'h84 && p <= 16'h86) return 4;
    return 0;
  endfunction

  task automatic do_reset();
    wr_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int c = 0; c < 4; c++) begin m_lo[c] = 0; m_hi[c] = 0; m_pg[c] = 0; end
    m_tog = 0; m_fat = 0;
    @(negedge clk_i);
    check(!pass_o && !xlate_req_o && !fatal_o && xlate_chan_o == 0, "R1 outputs",
          {pass_o, xlate_req_o, fatal_o, xlate_chan_o}, 0);
  endtask

  task automatic do_write(logic [15:0] p, logic [7:0] d, string tag_in);
    int ch, k;
    bit e_pass, e_req;
    logic [19:0] e_va;
    string tag;
    k = kind_of(p, ch);
    e_pass = 0; e_req = 0; e_va = '0;
    if (m_fat) tag = "R9";
    else begin
      case (k)
        1: begin
          tag = "R2";
          if (!m_tog) m_lo[ch] = d; else m_hi[ch] = d;
          m_tog = !m_tog;
        end
        2: begin tag = "R4"; m_tog = 0; e_pass = 1; end
        3: begin
          if (d >= 8'h10) begin tag = "R6"; m_fat = 1; end
          else begin
            tag = "R5"; m_pg[ch] = d[3:0]; e_req = 1;
            e_va = {m_pg[ch], m_hi[ch], m_lo[ch]};
          end
        end
        4: begin tag = "R7"; m_fat = 1; end
        default: begin tag = "R8"; e_pass = 1; end
      endcase
    end
    if (tag_in != "") tag = tag_in;
    @(negedge clk_i);
    wr_valid_i = 1'b1; wr_port_i = p; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    check(pass_o == e_pass, {tag, " pass"}, pass_o, e_pass);
    check(xlate_req_o == e_req, {tag, " req"}, xlate_req_o, e_req);
    check(fatal_o == m_fat, {tag, " fatal"}, fatal_o, m_fat);
    if (e_req) begin
      check(xlate_chan_o == 2'(ch), {tag, " chan"}, xlate_chan_o, ch);
      check(xlate_vaddr_o == e_va, {tag, " vaddr"}, xlate_vaddr_o, e_va);
    end
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    check(!pass_o && !xlate_req_o, "R10 idle", {pass_o, xlate_req_o}, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] ports [13] = '{16'h0, 16'h2, 16'h4, 16'h6, 16'h0C, 16'h81, 16'h82,
                                16'h83, 16'h87, 16'h01, 16'h08, 16'h80, 16'h3F0};
    void'($urandom(32'd1234));
    do_reset();
    do_write(16'h87, 8'h00, "R1 shadow zero");
    // R2: two bytes on channel 2 then page 5
    do_write(16'h04, 8'h34, "");
    do_write(16'h04, 8'h12, "");
    do_write(16'h81, 8'h05, "");
    idle_check();
    // R3: shared toggle across channels
    do_write(16'h0C, 8'h00, "");
    do_write(16'h00, 8'hAA, "");
    do_write(16'h02, 8'hBB, "");
    do_write(16'h83, 8'h01, "R3");
    do_write(16'h87, 8'h02, "R3");
    // R4: pointer reset between halves
    do_write(16'h06, 8'h11, "");
    do_write(16'h0C, 8'h00, "");
    do_write(16'h06, 8'h22, "");
    do_write(16'h82, 8'h0F, "R4 boundary page");
    // R8: untracked ports leave state intact
    do_write(16'h01, 8'h99, "");
    do_write(16'h08, 8'h77, "");
    do_write(16'h80, 8'h66, "");
    do_write(16'h06, 8'h33, "");
    do_write(16'h82, 8'h03, "R8 unchanged");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] p;
      logic [7:0] d;
      p = ports[$urandom_range(0, 12)];
      d = 8'($urandom());
      if (p inside {16'h81, 16'h82, 16'h83, 16'h87}) d = d & 8'h0F;
      do_write(p, d, "");
      if ($urandom_range(0, 7) == 0) idle_check();
    end
    // R6 boundary, then R9 sticky
    do_write(16'h87, 8'h10, "");
    do_write(16'h0C, 8'h00, "");
    do_write(16'h83, 8'h01, "");
    do_write(16'h00, 8'h55, "");
    idle_check();
    // R6 page shadow untouched by the rejected write
    do_reset();
    do_write(16'h00, 8'h44, "");
    do_write(16'h00, 8'h33, "");
    do_write(16'h87, 8'h02, "");
    do_reset();
    do_write(16'h00, 8'h44, "");
    do_write(16'h00, 8'h33, "");
    do_write(16'h83, 8'hF1, "");
    do_write(16'h81, 8'h01, "R9 after R6");
    // R7 gap ports
    do_reset();
    do_write(16'h84, 8'h00, "");
    do_reset();
    do_write(16'h85, 8'h01, "");
    do_reset();
    do_write(16'h86, 8'h02, "");
    do_write(16'h3F0, 8'h02, "");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule